// File: doc/BRIEF.md
# Burst SRAM Cycle Decoder

This block sits at the control-pin boundary of a pipelined burst SRAM. On every rising clock edge it samples three chip enables, two address strobes, a burst-advance input and the write controls. It then decides what kind of cycle the memory performs. There are two address strobes. The processor strobe only counts while the first chip enable is asserted. The controller strobe counts at any time, but ranks below the processor strobe.

The classified cycle goes out in registered form for use in the following clock cycle. The outputs are a cycle code, a load strobe and an advance strobe for the address sequencer, a write flag, a per-byte write mask and a flag showing that the device is selected. A deselect is sticky. After the device has been deselected, continue and suspend cycles leave it deselected until a new burst begins with the chip selected.

Top module: `bsram_cycle_decoder`

## Requirements
- R1: The chip counts as selected only when `ce_a_n`=0, `ce_b`=1 and `ce_c_n`=0. A burst-start cycle seen while the chip is not selected produces a deselect: `cyc_o`=0, `sel_o`=0, `load_o`=0.
- R2: While `ce_a_n`=1, `ads_ctrl_n`=0 forces a deselect. `ads_proc_n` has no effect: with `ads_ctrl_n`=1 the cycle is decided by `adv_n` alone.
- R3: With `ads_proc_n`=0 and the chip selected, the cycle is a read begin (`cyc_o`=1, `wr_o`=0, `wmask_o`=0). The write inputs have no effect.
- R4: With `ads_proc_n`=1, `ads_ctrl_n`=0 and the chip selected, a burst begins. It is a write begin (`cyc_o`=2) when the write term is active and a read begin (`cyc_o`=1) otherwise.
- R5: The write term is active when `gwr_n`=0. It is also active when `bwe_n`=0 and at least one bit of `bw_n` is 0. Otherwise it is inactive. `wr_o` shows the write term on begin-by-controller, continue and suspend cycles.
- R6: On a write cycle, `gwr_n`=0 sets every bit of `wmask_o`. Otherwise `wmask_o[i]` = !`bw_n[i]`. On read and deselect cycles `wmask_o` is 0.
- R7: With both strobes high and the device active, `adv_n`=0 gives continue (`cyc_o`=3, `adv_o`=1) and `adv_n`=1 gives suspend (`cyc_o`=4, `adv_o`=0). The chip enables are ignored.
- R8: Once deselected, continue and suspend cycles keep `sel_o`=0 and `cyc_o`=0 until a begin cycle occurs with the chip selected.
- R9: All outputs are registered. They reflect the inputs sampled at the previous rising edge. During and after reset: `cyc_o`=0, `sel_o`=0, and `load_o`, `adv_o`, `wr_o` and `wmask_o` are all 0.
- R10: `load_o` is 1 exactly on read-begin and write-begin cycles. `adv_o` is 1 exactly on continue cycles. The two are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_a_n | input | 1 | First chip enable, active low |
| ce_b | input | 1 | Second chip enable, active high |
| ce_c_n | input | 1 | Third chip enable, active low |
| ads_proc_n | input | 1 | Processor address strobe, active low |
| ads_ctrl_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gwr_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bw_n | input | NBYTE | Byte-write strobes, active low |
| cyc_o | output | 3 | Registered cycle code (0 deselect, 1 read begin, 2 write begin, 3 continue, 4 suspend) |
| load_o | output | 1 | Load the external address into the sequencer |
| adv_o | output | 1 | Advance the burst address |
| wr_o | output | 1 | Registered write flag |
| wmask_o | output | NBYTE | Registered per-byte write mask |
| sel_o | output | 1 | Device is selected (not in the sticky deselect state) |

## Verification
The only internal state is the sticky selected bit, and `sel_o` exposes it directly. A wrong value shows on the very next edge. A device that is wrongly active reports continue or suspend where deselect is expected. A device that is wrongly idle reports deselect where continue or suspend is expected. Decode errors in the strobe priority or the write term show one cycle after the offending inputs, in `cyc_o`, `wr_o` or `wmask_o`. The reference model is compared on every clock, so the first bad cycle is caught.

// File: rtl/bsram_dec_pkg.sv
// Package: shared cycle codes for the burst SRAM cycle decoder.
// Assumes: a 3-bit code is wide enough for all five cycle kinds.
package bsram_dec_pkg;
    localparam int CYC_W = 3;

    typedef enum logic [CYC_W-1:0] {
        CYC_DESEL    = 3'd0,
        CYC_RD_BEGIN = 3'd1,
        CYC_WR_BEGIN = 3'd2,
        CYC_CONT     = 3'd3,
        CYC_SUSP     = 3'd4
    } cyc_kind_e;
endpackage

// File: rtl/bsram_enable_decode.sv
// Module: combines the chip enables and the two address strobes.
// Produces the chip-select term and the qualified start requests.
// Assumes: every input is active at the levels noted, sampled before the edge.
module bsram_enable_decode (
    input  logic ce_a_n,
    input  logic ce_b,
    input  logic ce_c_n,
    input  logic ads_proc_n,
    input  logic ads_ctrl_n,
    output logic chip_sel,
    output logic start_proc,
    output logic start_ctrl
);
    // Purpose: qualify the strobes; the processor strobe needs the first enable and ranks first.
    always_comb begin
        chip_sel   = !ce_a_n && ce_b && !ce_c_n;
        start_proc = !ads_proc_n && !ce_a_n;
        start_ctrl = !ads_ctrl_n && !start_proc;
    end
endmodule

// File: rtl/bsram_write_decode.sv
// Module: builds the per-byte write mask and the combined write term.
// Assumes: a global write enables every byte; otherwise bytes need bwe_n low.
module bsram_write_decode #(
    parameter int NBYTE = 4
) (
    input  logic             gwr_n,
    input  logic             bwe_n,
    input  logic [NBYTE-1:0] bw_n,
    output logic [NBYTE-1:0] mask,
    output logic             wterm
);
    genvar gi;
    generate
        for (gi = 0; gi < NBYTE; gi++) begin : g_byte
            // Purpose: one byte lane is written under global write or its own strobe.
            always_comb begin
                mask[gi] = !gwr_n || (!bwe_n && !bw_n[gi]);
            end
        end
    endgenerate

    // Purpose: the cycle is a write when any lane is enabled.
    always_comb begin
        wterm = |mask;
    end
endmodule

// File: rtl/bsram_cycle_fsm.sv
// Module: classifies each cycle and registers the result, including the
// sticky selected state.
// Assumes: the start requests are already prioritised by the enable decoder.
module bsram_cycle_fsm
    import bsram_dec_pkg::*;
#(
    parameter int NBYTE = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chip_sel,
    input  logic             start_proc,
    input  logic             start_ctrl,
    input  logic             adv_n,
    input  logic             wterm,
    input  logic [NBYTE-1:0] mask,
    output cyc_kind_e        cyc_q,
    output logic             load_q,
    output logic             adv_q,
    output logic             wr_q,
    output logic [NBYTE-1:0] mask_q,
    output logic             active_q
);
    cyc_kind_e        cyc_d;
    logic             load_d, adv_d, wr_d, active_d;
    logic [NBYTE-1:0] mask_d;

    // Purpose: next-cycle decode from the strobes, the advance input and the sticky state.
    always_comb begin
        cyc_d    = CYC_DESEL;
        load_d   = 1'b0;
        adv_d    = 1'b0;
        wr_d     = 1'b0;
        mask_d   = '0;
        active_d = active_q;
        if (start_proc || start_ctrl) begin
            active_d = chip_sel;
            if (chip_sel) begin
                load_d = 1'b1;
                if (start_ctrl && wterm) begin
                    cyc_d  = CYC_WR_BEGIN;
                    wr_d   = 1'b1;
                    mask_d = mask;
                end else begin
                    cyc_d = CYC_RD_BEGIN;
                end
            end
        end else if (active_q) begin
            wr_d   = wterm;
            mask_d = mask;
            if (!adv_n) begin
                cyc_d = CYC_CONT;
                adv_d = 1'b1;
            end else begin
                cyc_d = CYC_SUSP;
            end
        end
    end

    // Purpose: register the classified cycle for use in the following clock cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_q    <= CYC_DESEL;
            load_q   <= 1'b0;
            adv_q    <= 1'b0;
            wr_q     <= 1'b0;
            mask_q   <= '0;
            active_q <= 1'b0;
        end else begin
            cyc_q    <= cyc_d;
            load_q   <= load_d;
            adv_q    <= adv_d;
            wr_q     <= wr_d;
            mask_q   <= mask_d;
            active_q <= active_d;
        end
    end
endmodule

// File: rtl/bsram_cycle_decoder.sv
// Module: top of the burst SRAM cycle decoder. It ties together the enable
// decoder, the write decoder and the cycle state machine.
// Assumes: all inputs are synchronous to clk; reset is synchronous active-low.
module bsram_cycle_decoder
    import bsram_dec_pkg::*;
#(
    parameter int NBYTE = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce_a_n,
    input  logic             ce_b,
    input  logic             ce_c_n,
    input  logic             ads_proc_n,
    input  logic             ads_ctrl_n,
    input  logic             adv_n,
    input  logic             gwr_n,
    input  logic             bwe_n,
    input  logic [NBYTE-1:0] bw_n,
    output logic [CYC_W-1:0] cyc_o,
    output logic             load_o,
    output logic             adv_o,
    output logic             wr_o,
    output logic [NBYTE-1:0] wmask_o,
    output logic             sel_o
);
    logic             chip_sel, start_proc, start_ctrl, wterm;
    logic [NBYTE-1:0] mask;
    cyc_kind_e        cyc_q;

    bsram_enable_decode u_en (
        .ce_a_n     (ce_a_n),
        .ce_b       (ce_b),
        .ce_c_n     (ce_c_n),
        .ads_proc_n (ads_proc_n),
        .ads_ctrl_n (ads_ctrl_n),
        .chip_sel   (chip_sel),
        .start_proc (start_proc),
        .start_ctrl (start_ctrl)
    );

    bsram_write_decode #(.NBYTE(NBYTE)) u_wr (
        .gwr_n (gwr_n),
        .bwe_n (bwe_n),
        .bw_n  (bw_n),
        .mask  (mask),
        .wterm (wterm)
    );

    bsram_cycle_fsm #(.NBYTE(NBYTE)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .chip_sel   (chip_sel),
        .start_proc (start_proc),
        .start_ctrl (start_ctrl),
        .adv_n      (adv_n),
        .wterm      (wterm),
        .mask       (mask),
        .cyc_q      (cyc_q),
        .load_q     (load_o),
        .adv_q      (adv_o),
        .wr_q       (wr_o),
        .mask_q     (wmask_o),
        .active_q   (sel_o)
    );

    // Purpose: present the cycle code as a plain vector at the port.
    always_comb begin
        cyc_o = cyc_q;
    end
endmodule

// File: rtl/bsram_cycle_decoder_chk.sv
// Module: protocol checker for the cycle decoder, attached with bind.
// Assumes: properties are sampled on the rising edge and disabled in reset.
module bsram_cycle_decoder_chk #(
    parameter int NBYTE = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ce_a_n,
    input logic             ce_b,
    input logic             ce_c_n,
    input logic             ads_proc_n,
    input logic             ads_ctrl_n,
    input logic             adv_n,
    input logic             gwr_n,
    input logic [2:0]       cyc_o,
    input logic             load_o,
    input logic             adv_o,
    input logic             wr_o,
    input logic [NBYTE-1:0] wmask_o,
    input logic             sel_o
);
    AST_SEL_BEGIN_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!ads_ctrl_n && (ce_b == 1'b0)) |=> (!sel_o && cyc_o == 3'd0)); // R1
    AST_CE_A_FORCES_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_a_n && !ads_ctrl_n) |=> (!sel_o && !load_o && cyc_o == 3'd0)); // R2
    AST_PROC_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (!ads_proc_n && !ce_a_n && ce_b && !ce_c_n) |=> (cyc_o == 3'd1 && !wr_o && wmask_o == '0)); // R3
    AST_GLOBAL_WRITE_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (ads_proc_n && !ads_ctrl_n && !ce_a_n && ce_b && !ce_c_n && !gwr_n) |=> (cyc_o == 3'd2 && wmask_o == '1)); // R6
    AST_CONT_IGNORES_CE: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_o && ads_ctrl_n && (ads_proc_n || ce_a_n) && !adv_n) |=> (adv_o && cyc_o == 3'd3)); // R7
    AST_STICKY_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_o && ads_ctrl_n && (ads_proc_n || ce_a_n)) |=> (!sel_o && cyc_o == 3'd0)); // R8
    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({load_o, adv_o})); // R10
    AST_MASK_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wmask_o != '0) |-> wr_o); // R6
endmodule

bind bsram_cycle_decoder bsram_cycle_decoder_chk #(.NBYTE(NBYTE)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ce_a_n     (ce_a_n),
    .ce_b       (ce_b),
    .ce_c_n     (ce_c_n),
    .ads_proc_n (ads_proc_n),
    .ads_ctrl_n (ads_ctrl_n),
    .adv_n      (adv_n),
    .gwr_n      (gwr_n),
    .cyc_o      (cyc_o),
    .load_o     (load_o),
    .adv_o      (adv_o),
    .wr_o       (wr_o),
    .wmask_o    (wmask_o),
    .sel_o      (sel_o)
);

// File: tb/bsram_cycle_decoder_test.sv
// Bench: drives control patterns on the falling edge. A behavioural model
// predicts the registered outputs, and they are compared every clock.
module bsram_cycle_decoder_test;
    localparam int NB = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_a_n = 1'b1, ce_b = 1'b0, ce_c_n = 1'b1;
    logic          ads_proc_n = 1'b1, ads_ctrl_n = 1'b1, adv_n = 1'b1;
    logic          gwr_n = 1'b1, bwe_n = 1'b1;
    logic [NB-1:0] bw_n = '1;
    logic [2:0]    cyc_o;
    logic          load_o, adv_o, wr_o, sel_o;
    logic [NB-1:0] wmask_o;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    // model state and pending expectations
    int     m_on = 0;
    int     e_cyc = 0, e_load = 0, e_adv = 0, e_wr = 0, e_sel = 0, e_mask = 0;
    string  e_tag = "R9";

    always #5 clk = ~clk;

    bsram_cycle_decoder #(.NBYTE(NB)) uut (
        .clk(clk), .rst_n(rst_n), .ce_a_n(ce_a_n), .ce_b(ce_b), .ce_c_n(ce_c_n),
        .ads_proc_n(ads_proc_n), .ads_ctrl_n(ads_ctrl_n), .adv_n(adv_n),
        .gwr_n(gwr_n), .bwe_n(bwe_n), .bw_n(bw_n), .cyc_o(cyc_o), .load_o(load_o),
        .adv_o(adv_o), .wr_o(wr_o), .wmask_o(wmask_o), .sel_o(sel_o)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        chk(e_tag, "cyc", int'(cyc_o), e_cyc);
        chk(e_tag, "sel", int'(sel_o), e_sel);
        chk((e_load != 0) ? "R10" : e_tag, "load", int'(load_o), e_load);
        chk((e_adv != 0) ? "R10" : e_tag, "adv", int'(adv_o), e_adv);
        chk((e_tag == "R3") ? "R3" : "R5", "wr", int'(wr_o), e_wr);
        chk((e_tag == "R3") ? "R3" : "R6", "mask", int'(wmask_o), e_mask);
    endtask

    // behavioural prediction of the next registered outputs
    task automatic predict();
        int  lane_mask = 0;
        bit  sel_now, proc_go, ctrl_go;
        for (int i = 0; i < NB; i++)
            if (gwr_n == 1'b0 || (bwe_n == 1'b0 && bw_n[i] == 1'b0)) lane_mask |= (1 << i);
        sel_now = (ce_a_n == 1'b0) && (ce_b == 1'b1) && (ce_c_n == 1'b0);
        proc_go = (ads_proc_n == 1'b0) && (ce_a_n == 1'b0);
        ctrl_go = (ads_ctrl_n == 1'b0) && !proc_go;
        e_cyc = 0; e_load = 0; e_adv = 0; e_wr = 0; e_mask = 0;
        if (proc_go || ctrl_go) begin
            if (!sel_now) begin
                m_on = 0;
                e_tag = (ce_a_n == 1'b1) ? "R2" : "R1";
            end else begin
                m_on = 1; e_load = 1;
                if (proc_go) begin
                    e_cyc = 1; e_tag = "R3";
                end else if (lane_mask != 0) begin
                    e_cyc = 2; e_wr = 1; e_mask = lane_mask; e_tag = "R4";
                end else begin
                    e_cyc = 1; e_tag = "R4";
                end
            end
        end else if (m_on == 0) begin
            e_tag = "R8";
        end else begin
            e_tag = "R7";
            e_wr = (lane_mask != 0) ? 1 : 0;
            e_mask = lane_mask;
            if (adv_n == 1'b0) begin e_cyc = 3; e_adv = 1; end
            else e_cyc = 4;
        end
        e_sel = m_on;
    endtask

    // one clock: check the previous prediction, then apply and predict
    task automatic step(input bit a, input bit b, input bit c, input bit p, input bit q,
                        input bit v, input bit g, input bit e, input logic [NB-1:0] w);
        @(negedge clk);
        compare_all();
        ce_a_n = a; ce_b = b; ce_c_n = c; ads_proc_n = p; ads_ctrl_n = q;
        adv_n = v; gwr_n = g; bwe_n = e; bw_n = w;
        predict();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset values while reset is held
        e_tag = "R9";
        compare_all();
        rst_n = 1'b1;
        // R1: begin requests without full select
        step(0, 0, 0, 0, 1, 1, 0, 0, 4'h0);
        step(0, 1, 1, 1, 0, 1, 1, 1, 4'hF);
        // R8: stays deselected
        step(0, 1, 0, 1, 1, 0, 1, 1, 4'hF);
        step(0, 1, 0, 1, 1, 1, 1, 1, 4'hF);
        // R3: processor begin with global write active is still a read
        step(0, 1, 0, 0, 0, 1, 0, 0, 4'h0);
        // R7: continue, suspend, enables ignored
        step(1, 0, 1, 1, 1, 0, 1, 1, 4'hF);
        step(1, 0, 1, 1, 1, 1, 1, 1, 4'hF);
        // R2: processor strobe ignored while first enable high
        step(1, 0, 0, 0, 1, 0, 1, 1, 4'hF);
        // R4 / R6: controller write via global write
        step(0, 1, 0, 1, 0, 1, 0, 1, 4'hF);
        // R4 / R6: byte subset
        step(0, 1, 0, 1, 0, 1, 1, 0, 4'b1010);
        // R5: bwe low but no strobe is a read
        step(0, 1, 0, 1, 0, 1, 1, 0, 4'hF);
        // R5: strobes low but bwe high is a read
        step(0, 1, 0, 1, 0, 1, 1, 1, 4'h0);
        // R7 write continue and suspend with mask
        step(0, 1, 0, 1, 1, 0, 1, 0, 4'b0110);
        step(0, 1, 0, 1, 1, 1, 0, 1, 4'hF);
        // R2: controller strobe with first enable high forces deselect
        step(1, 1, 0, 0, 0, 0, 0, 0, 4'h0);
        step(0, 1, 0, 1, 1, 0, 0, 0, 4'h0);
        // mixed patterns
        for (int k = 0; k < 600; k++) begin
            logic [11:0] r;
            r = 12'($urandom);
            step(r[0] & r[1], r[2] | r[3], r[4] & r[5], r[6] | r[7], r[8] | r[9],
                 r[10], r[11] | r[3], r[5], 4'($urandom));
        end
        @(negedge clk);
        compare_all();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule